// File: doc/BRIEF.md
# Cross-Processor Byte Mailbox

This block links a host processor and a guest console processor through one byte of mailbox storage in each direction. The host sees two registers through a chip select, separate read and write strobes and a small address field. One register holds control and status and the other holds data. The guest has no read/write line. It reaches its side of the mailbox through two separately decoded strobes, one to fetch a byte and one to deposit a byte.

The two sides appear to share one byte, but the storage is split into two one-way latches. Each latch has a flag that is set when the writer loads it and cleared when the reader takes it. The host polls the status bits before it sends a byte and before it collects one.

A host write to the control register also sets three fields that leave the block: a memory page number, a memory ownership select and a mailbox enable. Both ports run on one system clock and use strobes that last one cycle. The reset input is asserted asynchronously and released synchronously inside the block.

Top module: `xmb_mailbox`

## Requirements
- R1: After reset, a host control read returns 0x80 (guest-bound latch empty, host-bound latch empty), and the page, ownership and enable outputs are all zero.
- R2: Only host address bit 0 selects the register: an even address reaches control/status and an odd address reaches data, at every offset 0x0 to 0xF.
- R3: A host control write stores data bits 3:0 as the page, bit 4 as the memory ownership select and bit 5 as the mailbox enable, all visible on the outputs the next cycle. Bits 7:6 of the written value are discarded.
- R4: A host control read returns bit 7 = 1 when the guest-bound latch is empty, bit 6 = 1 when the host-bound latch holds a byte, and zeros in bits 5:0.
- R5: A host data write loads the guest-bound latch, which appears on the guest read bus the next cycle. Bit 7 of the status reads 0 from then on.
- R6: A guest read strobe sets bit 7 of the status again. A guest read of an empty latch returns the last byte written, with no error, and bit 7 stays 1.
- R7: A guest write strobe loads the host-bound latch and sets bit 6 of the status the next cycle.
- R8: A host data read returns the host-bound latch in the same cycle and clears bit 6 the next cycle.
- R9: When a flag is set and cleared in the same cycle, the set wins and the new byte is kept.
- R10: Host strobes with the chip select low change neither the flags nor the control fields.
- R11: A host data access leaves the control fields unchanged, and a host control write leaves both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock shared by both ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs | input | 1 | Host chip select |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 4 | Host address; only bit 0 is decoded |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (status or host-bound byte) |
| guest_rd_stb | input | 1 | Guest fetch of the guest-bound byte |
| guest_wr_stb | input | 1 | Guest deposit into the host-bound latch |
| guest_wdata | input | 8 | Guest write data |
| guest_rdata | output | 8 | Guest-bound latch contents |
| page_o | output | 4 | Memory page number |
| ram_owner_o | output | 1 | Memory ownership select |
| mbox_en_o | output | 1 | Mailbox enable |

## Verification
The bench uses the default widths: an 8-bit data path, a 4-bit page and a 4-bit host address. With these widths it can reach every one of the sixteen host offsets, so the mirroring of the register pair can be checked at both even and odd addresses across the whole range. It also places each status flag at bit 7 and bit 6 as the host software expects. The 4-bit page field leaves bits 7:6 of a control write free to show that they are discarded.

// File: rtl/xmb_pkg.sv
package xmb_pkg;
  localparam int XMB_DATA_W = 8;
  localparam int XMB_PAGE_W = 4;
  localparam int XMB_ADDR_W = 4;

  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_DATA = 1'b1
  } xmb_sel_e;
endpackage

// File: rtl/xmb_chan.sv
module xmb_chan #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] wdata,
  input  logic         take,
  output logic [W-1:0] q,
  output logic         full
);
  logic [W-1:0] data_d, data_q;
  logic         full_d, full_q;

  always_comb begin
    data_d = data_q;
    full_d = full_q;
    if (take) full_d = 1'b0;
    if (load) begin
      data_d = wdata;
      full_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      full_q <= 1'b0;
    end else begin
      full_q <= full_d;
      if (load) data_q <= data_d;
    end
  end

  assign q    = data_q;
  assign full = full_q;

  // R5/R7/R9: a load always leaves the latch full with the new byte
  a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (full && q == $past(wdata)));
  // R6/R8: a take with no load empties the latch
  a_r6_take_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !load) |=> !full);
  // R6: a stale fetch does not disturb the stored byte
  a_r6_byte_held: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));
endmodule

// File: rtl/xmb_ctrl.sv
module xmb_ctrl #(
  parameter int DW     = 8,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DW-1:0]     wdata,
  output logic [PAGE_W-1:0] page,
  output logic              owner,
  output logic              en
);
  localparam int OWN_BIT = PAGE_W;
  localparam int EN_BIT  = PAGE_W + 1;
  localparam int FW      = PAGE_W + 2;

  logic [FW-1:0] fld_d, fld_q;

  always_comb begin
    fld_d = fld_q;
    if (wr) fld_d = wdata[FW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fld_q <= '0;
    else if (wr) fld_q <= fld_d;
  end

  assign page  = fld_q[PAGE_W-1:0];
  assign owner = fld_q[OWN_BIT];
  assign en    = fld_q[EN_BIT];

  // R3: written fields appear on the outputs one cycle later
  a_r3_fields_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (page == $past(wdata[PAGE_W-1:0]) && owner == $past(wdata[OWN_BIT])
            && en == $past(wdata[EN_BIT])));
  // R11: fields hold without a control write
  a_r11_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> ($stable(page) && $stable(owner) && $stable(en)));
endmodule

// File: rtl/xmb_host_if.sv
module xmb_host_if
  import xmb_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          host_cs,
  input  logic          host_rd,
  input  logic          host_wr,
  input  logic [AW-1:0] host_addr,
  input  logic          h2g_full,
  input  logic          g2h_full,
  input  logic [DW-1:0] g2h_data,
  output logic          ctrl_wr,
  output logic          data_wr,
  output logic          data_rd,
  output logic [DW-1:0] rdata
);
  xmb_sel_e sel;

  always_comb begin
    sel     = xmb_sel_e'(host_addr[0]);
    ctrl_wr = host_cs && host_wr && (sel == SEL_CTRL);
    data_wr = host_cs && host_wr && (sel == SEL_DATA);
    data_rd = host_cs && host_rd && (sel == SEL_DATA);
    rdata   = '0;
    if (sel == SEL_DATA) begin
      rdata = g2h_data;
    end else begin
      rdata[DW-1] = !h2g_full;
      rdata[DW-2] = g2h_full;
    end
  end
endmodule

// File: rtl/xmb_mailbox.sv
module xmb_mailbox
  import xmb_pkg::*;
#(
  parameter int DATA_W = XMB_DATA_W,
  parameter int PAGE_W = XMB_PAGE_W,
  parameter int ADDR_W = XMB_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_cs,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              guest_rd_stb,
  input  logic              guest_wr_stb,
  input  logic [DATA_W-1:0] guest_wdata,
  output logic [DATA_W-1:0] guest_rdata,
  output logic [PAGE_W-1:0] page_o,
  output logic              ram_owner_o,
  output logic              mbox_en_o
);
  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_N-1];

  logic              ctrl_wr, data_wr, data_rd;
  logic              h2g_full, g2h_full;
  logic [DATA_W-1:0] g2h_q;

  xmb_host_if #(.DW(DATA_W), .AW(ADDR_W)) u_host (
    .host_cs  (host_cs),
    .host_rd  (host_rd),
    .host_wr  (host_wr),
    .host_addr(host_addr),
    .h2g_full (h2g_full),
    .g2h_full (g2h_full),
    .g2h_data (g2h_q),
    .ctrl_wr  (ctrl_wr),
    .data_wr  (data_wr),
    .data_rd  (data_rd),
    .rdata    (host_rdata)
  );

  xmb_chan #(.W(DATA_W)) u_h2g (
    .clk  (clk),
    .rst_n(rst_int_n),
    .load (data_wr),
    .wdata(host_wdata),
    .take (guest_rd_stb),
    .q    (guest_rdata),
    .full (h2g_full)
  );

  xmb_chan #(.W(DATA_W)) u_g2h (
    .clk  (clk),
    .rst_n(rst_int_n),
    .load (guest_wr_stb),
    .wdata(guest_wdata),
    .take (data_rd),
    .q    (g2h_q),
    .full (g2h_full)
  );

  xmb_ctrl #(.DW(DATA_W), .PAGE_W(PAGE_W)) u_ctrl (
    .clk  (clk),
    .rst_n(rst_int_n),
    .wr   (ctrl_wr),
    .wdata(host_wdata),
    .page (page_o),
    .owner(ram_owner_o),
    .en   (mbox_en_o)
  );

  // R8: host data read with no guest write empties the host-bound latch
  a_r8_host_take: assert property (@(posedge clk) disable iff (!rst_int_n)
    (host_cs && host_rd && host_addr[0] && !guest_wr_stb) |=> !g2h_full);
  // R5: host data write leaves the guest-bound latch full
  a_r5_host_load: assert property (@(posedge clk) disable iff (!rst_int_n)
    (host_cs && host_wr && host_addr[0]) |=> h2g_full);
  // R10: no chip select and no guest strobe keeps both flags
  a_r10_idle_flags: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!host_cs && !guest_rd_stb && !guest_wr_stb) |=> ($stable(h2g_full) && $stable(g2h_full)));
  // R11: a control write alone leaves both flags
  a_r11_ctrl_keeps_flags: assert property (@(posedge clk) disable iff (!rst_int_n)
    (host_cs && host_wr && !host_addr[0] && !guest_rd_stb && !guest_wr_stb)
      |=> ($stable(h2g_full) && $stable(g2h_full)));
endmodule

// File: tb/xmb_mailbox_test.sv
module xmb_mailbox_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       host_cs, host_rd, host_wr;
  logic [3:0] host_addr;
  logic [7:0] host_wdata, host_rdata;
  logic       guest_rd_stb, guest_wr_stb;
  logic [7:0] guest_wdata, guest_rdata;
  logic [3:0] page_o;
  logic       ram_owner_o, mbox_en_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  xmb_mailbox uut (
    .clk(clk), .rst_n(rst_n),
    .host_cs(host_cs), .host_rd(host_rd), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .guest_rd_stb(guest_rd_stb), .guest_wr_stb(guest_wr_stb),
    .guest_wdata(guest_wdata), .guest_rdata(guest_rdata),
    .page_o(page_o), .ram_owner_o(ram_owner_o), .mbox_en_o(mbox_en_o)
  );

  // op: 0 host write, 1 host read (checked), 2 guest write, 3 guest read (checked)
  // fields: {req[7:0], op[3:0], addr[3:0], wdata[7:0], expect[7:0]}
  localparam int NV = 18;
  localparam logic [31:0] VEC [NV] = '{
    {8'd1, 4'd1, 4'h0, 8'h00, 8'h80}, // R1 reset status
    {8'd3, 4'd0, 4'h2, 8'hF5, 8'h00}, // R3 control write, bits 7:6 dropped
    {8'd11,4'd1, 4'h4, 8'h00, 8'h80}, // R11 flags unchanged by control write
    {8'd5, 4'd0, 4'h3, 8'h5A, 8'h00}, // R5 host data write
    {8'd5, 4'd1, 4'hE, 8'h00, 8'h00}, // R5 bit 7 now clear
    {8'd5, 4'd3, 4'h0, 8'h00, 8'h5A}, // R5 guest sees byte
    {8'd6, 4'd1, 4'h0, 8'h00, 8'h80}, // R6 bit 7 set again
    {8'd7, 4'd2, 4'h0, 8'h46, 8'h00}, // R7 guest write
    {8'd7, 4'd1, 4'h6, 8'h00, 8'hC0}, // R7 bit 6 set
    {8'd8, 4'd1, 4'hF, 8'h00, 8'h46}, // R8 data read
    {8'd8, 4'd1, 4'h8, 8'h00, 8'h80}, // R8 bit 6 cleared
    {8'd6, 4'd3, 4'h0, 8'h00, 8'h5A}, // R6 stale fetch
    {8'd6, 4'd1, 4'hA, 8'h00, 8'h80}, // R6 bit 7 stays set
    {8'd7, 4'd2, 4'h0, 8'h00, 8'h00}, // R7 guest writes zero
    {8'd2, 4'd1, 4'hC, 8'h00, 8'hC0}, // R2 mirror at 0xC
    {8'd2, 4'd1, 4'h1, 8'h00, 8'h00}, // R2 data at 0x1
    {8'd4, 4'd1, 4'h0, 8'h00, 8'h80}, // R4 low bits zero
    {8'd2, 4'd1, 4'h7, 8'h00, 8'h00}  // R2 data at 0x7 returns stale byte
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic idle();
    host_cs = 0; host_rd = 0; host_wr = 0; guest_rd_stb = 0; guest_wr_stb = 0;
  endtask

  // drive at negedge, sample 1ns later, release after the posedge
  task automatic step(input logic cs, input logic rd, input logic wr, input logic [3:0] a,
                      input logic [7:0] d, input logic grd, input logic gwr,
                      input logic [7:0] gd, output logic [7:0] hq, output logic [7:0] gq);
    @(negedge clk);
    host_cs = cs; host_rd = rd; host_wr = wr; host_addr = a; host_wdata = d;
    guest_rd_stb = grd; guest_wr_stb = gwr; guest_wdata = gd;
    #1;
    hq = host_rdata; gq = guest_rdata;
    @(posedge clk); #1;
    idle();
  endtask

  task automatic status(output logic [7:0] s);
    logic [7:0] g;
    step(1, 1, 0, 4'h0, 8'h00, 0, 0, 8'h00, s, g);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] hq, gq, s;
    idle();
    host_addr = 0; host_wdata = 0; guest_wdata = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (4) @(posedge clk);

    // R1 reset fields
    check("R1 page", {4'h0, page_o}, 8'h00);
    check("R1 owner/en", {6'h0, ram_owner_o, mbox_en_o}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [7:0] req, d, e;
      logic [3:0] op, a;
      string tag;
      {req, op, a, d, e} = VEC[i];
      tag = $sformatf("R%0d vec%0d", req, i);
      case (op)
        4'd0: step(1, 0, 1, a, d, 0, 0, 8'h00, hq, gq);
        4'd1: begin step(1, 1, 0, a, 8'h00, 0, 0, 8'h00, hq, gq); check(tag, hq, e); end
        4'd2: step(0, 0, 0, a, 8'h00, 0, 1, d, hq, gq);
        default: begin step(0, 0, 0, a, 8'h00, 1, 0, 8'h00, hq, gq); check(tag, gq, e); end
      endcase
      if (i == 1) begin
        check("R3 page", {4'h0, page_o}, 8'h05);
        check("R3 owner/en", {6'h0, ram_owner_o, mbox_en_o}, 8'h03);
      end
    end

    // R11: data accesses left the control fields
    check("R11 page", {4'h0, page_o}, 8'h05);

    // R10: control write with chip select low is ignored
    step(0, 0, 1, 4'h0, 8'h0C, 0, 0, 8'h00, hq, gq);
    check("R10 page", {4'h0, page_o}, 8'h05);
    // R10: guest writes a byte; host data read with cs low must not clear bit 6
    step(0, 0, 0, 4'h0, 8'h00, 0, 1, 8'h33, hq, gq);
    step(0, 1, 0, 4'h1, 8'h00, 0, 0, 8'h00, hq, gq);
    status(s);
    check("R10 bit6 kept", s, 8'hC0);
    // R10: host data write with cs low leaves bit 7 set
    step(0, 0, 1, 4'h1, 8'h99, 0, 0, 8'h00, hq, gq);
    status(s);
    check("R10 bit7 kept", s, 8'hC0);

    // R9: guest write and host data read in the same cycle; read sees old byte, flag stays
    step(1, 1, 0, 4'h1, 8'h00, 0, 1, 8'h77, hq, gq);
    check("R9 old byte", hq, 8'h33);
    status(s);
    check("R9 bit6 set wins", s, 8'hC0);
    step(1, 1, 0, 4'h3, 8'h00, 0, 0, 8'h00, hq, gq);
    check("R9 new byte", hq, 8'h77);

    // R9: host data write and guest read in the same cycle
    step(1, 0, 1, 4'h5, 8'hA5, 1, 0, 8'h00, hq, gq);
    check("R9 guest old byte", gq, 8'h5A);
    status(s);
    check("R9 bit7 clear", s, 8'h00);
    step(0, 0, 0, 4'h0, 8'h00, 1, 0, 8'h00, hq, gq);
    check("R9 guest new byte", gq, 8'hA5);

    // R11: control write while a byte waits keeps the flags
    step(1, 0, 1, 4'h1, 8'hC1, 0, 0, 8'h00, hq, gq);
    step(1, 0, 1, 4'hA, 8'h2E, 0, 0, 8'h00, hq, gq);
    check("R3 page 0xE", {4'h0, page_o}, 8'h0E);
    check("R3 owner/en 10", {6'h0, ram_owner_o, mbox_en_o}, 8'h01);
    status(s);
    check("R11 flags kept", s, 8'h00);

    // R1: reset again clears everything
    @(negedge clk); rst_n = 0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (4) @(posedge clk);
    status(s);
    check("R1 status after reset", s, 8'h80);
    check("R1 page after reset", {4'h0, page_o}, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule